// File: doc/BRIEF.md
# Boot-Configured Peripheral Access Filter

This block sits between a single request/response initiator port and a row of peripheral slots. When a boot strobe arrives it captures three settings: which slots are fitted, which of them may only be reached by secure initiators, and two mode bits. It then spends one cycle per slot building its address map. After that it decodes every access and takes one of four actions. It forwards the access to exactly one slot, returns an error, or absorbs the access silently. It can also block the access at the firewall.

The map is built in one of two ways. In direct mode, window n always belongs to slot n, so a slot that is not fitted leaves a hole. In packed mode, the fitted slots are handed consecutive windows starting at window zero, in rising slot order, so software sees a gap-free map. A mode bit selects how a hole in the direct map is reported: as an error, or as a harmless access that reads zero. The peripherals themselves and the transport that carries requests are outside the block.

Top module: `periph_access_filter`

## Requirements
- R1: After reset, reqReady is low and no slot is selected. The block waits for bootStrobe. The strobe cycle is followed by exactly NUM_SLOTS build cycles with reqReady still low. reqReady is high from the next cycle onward.
- R2: The boot inputs (bootEnMask, bootSecMask, bootTrap, bootCompact) are captured only on the first bootStrobe after reset. A later strobe leaves reqReady high and leaves the map and the mode bits unchanged.
- R3: In direct mode (bootCompact=0), window w = reqAddr[ADDR_W-1:OFFS_W] is owned by slot w. A forwarded access raises bit w of slotSel in the same cycle that the access is accepted. In that cycle slotOffs carries reqAddr[OFFS_W-1:0], and slotWrite and slotWdata carry the request. The response follows one cycle later: rspErr=0, with the slot's read data for a read and zero for a write.
- R4: In packed mode (bootCompact=1), the fitted slots take windows 0, 1, 2 and onward in ascending slot index.
- R5: A window at or above the mapped limit returns rspErr=1 whatever the mode bits are, and no slot is selected. The limit is NUM_SLOTS in direct mode and the fitted-slot count in packed mode.
- R6: In direct mode with bootTrap=1, an access to the window of an unfitted slot returns rspErr=1 and selects no slot.
- R7: In direct mode with bootTrap=0, an access to an unfitted slot selects no slot and returns rspErr=0. A read of such a slot returns rspRdata=0.
- R8: An access with reqSecure=0 to a fitted slot whose secure bit is set returns rspErr=1 and is not forwarded. The same access with reqSecure=1 is forwarded.
- R9: Every accepted request (reqValid and reqReady) produces exactly one response with rspValid high in the following cycle, and rspValid is low otherwise. slotSel is at most one-hot and never selects an unfitted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootStrobe | input | 1 | Captures the boot settings and starts the map build |
| bootEnMask | input | NUM_SLOTS | Fitted-slot mask, one bit per slot |
| bootSecMask | input | NUM_SLOTS | Secure-only mask, one bit per slot |
| bootTrap | input | 1 | 1: holes return an error; 0: holes are silently absorbed |
| bootCompact | input | 1 | 1: packed map; 0: direct map |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block accepts requests (map built) |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write data |
| reqSecure | input | 1 | Initiator is secure |
| slotSel | output | NUM_SLOTS | One-hot select of the target slot |
| slotWrite | output | 1 | Write strobe toward the slot |
| slotOffs | output | OFFS_W | Offset inside the slot window |
| slotWdata | output | DATA_W | Write data toward the slot |
| slotRdata | input | NUM_SLOTS*DATA_W | Read data of all slots, slot i at bits i*DATA_W upward |
| rspValid | output | 1 | Response present |
| rspErr | output | 1 | Error response |
| rspRdata | output | DATA_W | Read data |

## Verification
The assertions check several properties on every cycle. slotSel stays one-hot or idle and never points at an unfitted slot. A secure-only slot is never selected by a non-secure request. Nothing is selected before the map is built. Responses line up one-to-one with accepted requests, and out-of-range accesses always answer with an error. Other behaviours can only be shown by the bench's scenarios. These are the exact window-to-slot assignment in packed mode, the length of the boot build, the split between trapping and absorbing holes, and the fact that a second strobe changes nothing. Each of these depends on a particular mask setting, and the bench's reference model predicts it for each access.

// File: rtl/paf_pkg.sv
`timescale 1ns/1ps
package paf_pkg;

  // Upper bound for the build index carried in the strobe struct
  localparam int unsigned CTL_IDX_W = 8;

  typedef enum logic [2:0] {
    OUT_FWD,
    OUT_RANGE,
    OUT_TRAP,
    OUT_IGNORE,
    OUT_FIREWALL
  } outcome_e;

  typedef struct packed {
    logic                 latchCfg;   // capture boot settings this cycle
    logic                 buildStep;  // one map entry is written this cycle
    logic [CTL_IDX_W-1:0] buildIdx;   // slot handled by the current step
    logic                 runMode;    // map complete, requests accepted
  } ctlStrobes_t;

endpackage

// File: rtl/paf_ctrl.sv
`timescale 1ns/1ps
module paf_ctrl
  import paf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bootStrobe,
  output ctlStrobes_t strobes
);

  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  typedef enum logic [1:0] {ST_WAIT, ST_BUILD, ST_RUN} state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_WAIT;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (bootStrobe) begin
            state <= ST_BUILD;
            idx   <= '0;
          end
        end
        ST_BUILD: begin
          if (idx == LAST_IDX) state <= ST_RUN;
          else                 idx   <= idx + 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.latchCfg  = (state == ST_WAIT) && bootStrobe;
    strobes.buildStep = (state == ST_BUILD);
    strobes.buildIdx  = CTL_IDX_W'(idx);
    strobes.runMode   = (state == ST_RUN);
  end

  // R2: once the map is built, nothing returns the block to boot
  a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runMode |=> strobes.runMode);

  // R1: run mode is entered only right after the last build step
  a_r1_enter_after_build: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.runMode) |-> $past(strobes.buildStep) && ($past(idx) == LAST_IDX));

  // R1: build begins only from a captured strobe
  a_r1_build_from_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.buildStep) |-> $past(strobes.latchCfg));

endmodule

// File: rtl/paf_datapath.sv
`timescale 1ns/1ps
module paf_datapath
  import paf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFFS_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobes_t                 strobes,
  input  logic [NUM_SLOTS-1:0]        bootEnMask,
  input  logic [NUM_SLOTS-1:0]        bootSecMask,
  input  logic                        bootTrap,
  input  logic                        bootCompact,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic                        reqSecure,
  output logic [NUM_SLOTS-1:0]        slotSel,
  output logic                        slotWrite,
  output logic [OFFS_W-1:0]           slotOffs,
  output logic [DATA_W-1:0]           slotWdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  output logic                        rspValid,
  output logic                        rspErr,
  output logic [DATA_W-1:0]           rspRdata
);

  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1);
  localparam int unsigned WIN_W = ADDR_W - OFFS_W;

  // Captured boot configuration
  logic [NUM_SLOTS-1:0] cfgEn;
  logic [NUM_SLOTS-1:0] cfgSec;
  logic                 cfgTrap;
  logic                 cfgCompact;

  // Map under construction / built
  logic [IDX_W-1:0] baseTab [NUM_SLOTS];
  logic [CNT_W-1:0] enCount;
  logic [IDX_W-1:0] stepIdx;

  assign stepIdx = strobes.buildIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn      <= '0;
      cfgSec     <= '0;
      cfgTrap    <= 1'b0;
      cfgCompact <= 1'b0;
      enCount    <= '0;
    end else if (strobes.latchCfg) begin
      cfgEn      <= bootEnMask;
      cfgSec     <= bootSecMask;
      cfgTrap    <= bootTrap;
      cfgCompact <= bootCompact;
      enCount    <= '0;
    end else if (strobes.buildStep) begin
      enCount <= enCount + CNT_W'(cfgEn[stepIdx]);
    end
  end

  // One map entry per slot, written in its own build step
  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseTab[gi] <= '0;
      end else if (strobes.buildStep && (stepIdx == IDX_W'(gi))) begin
        baseTab[gi] <= cfgCompact ? enCount[IDX_W-1:0] : IDX_W'(gi);
      end
    end
  end

  // Address decode
  logic [WIN_W-1:0]     winIdx;
  logic [31:0]          winExt;
  logic [31:0]          limitExt;
  logic                 inRange;
  logic [NUM_SLOTS-1:0] hitVec;
  logic [IDX_W-1:0]     selIdx;

  assign winIdx   = reqAddr[ADDR_W-1:OFFS_W];
  assign winExt   = 32'(winIdx);
  assign limitExt = cfgCompact ? 32'(enCount) : 32'(NUM_SLOTS);
  assign inRange  = winExt < limitExt;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_hit
    assign hitVec[gi] = cfgCompact ? (cfgEn[gi] && (32'(baseTab[gi]) == winExt))
                                   : (winExt == 32'(gi));
  end

  always_comb begin
    selIdx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
  end

  // Access verdict
  outcome_e outcome;
  logic     accept;
  logic     fwd;

  always_comb begin
    if (!inRange)                         outcome = OUT_RANGE;
    else if (!cfgEn[selIdx])              outcome = cfgTrap ? OUT_TRAP : OUT_IGNORE;
    else if (cfgSec[selIdx] && !reqSecure) outcome = OUT_FIREWALL;
    else                                  outcome = OUT_FWD;
  end

  assign accept = reqValid && strobes.runMode;
  assign fwd    = accept && (outcome == OUT_FWD);

  // Slot side: everything held quiet unless forwarded
  assign slotSel   = fwd ? hitVec : '0;
  assign slotWrite = fwd && reqWrite;
  assign slotOffs  = fwd ? reqAddr[OFFS_W-1:0] : '0;
  assign slotWdata = (fwd && reqWrite) ? reqWdata : '0;

  logic [DATA_W-1:0] pickData;
  assign pickData = slotRdata[int'(selIdx)*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= accept;
      rspErr   <= accept && (outcome inside {OUT_RANGE, OUT_TRAP, OUT_FIREWALL});
      rspRdata <= (fwd && !reqWrite) ? pickData : '0;
    end
  end

  // R9: at most one slot at a time
  a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel));

  // R9: an unfitted slot is never driven
  a_r9_sel_fitted: assert property (@(posedge clk) disable iff (!rstN)
    (slotSel & ~cfgEn) == '0);

  // R8: secure-only slots see secure initiators only
  a_r8_firewall_block: assert property (@(posedge clk) disable iff (!rstN)
    ((slotSel & cfgSec) != '0) |-> reqSecure);

  // R1: quiet slot side before the map is ready
  a_r1_quiet_boot: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runMode |-> (slotSel == '0));

  // R9: one response per accepted request, next cycle
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);
  a_r9_rsp_only_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);

  // R5: beyond the map always errors
  a_r5_range_error: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !inRange) |=> rspErr);

  // R7: absorbed access returns zero data and no error
  a_r7_ignore_zero: assert property (@(posedge clk) disable iff (!rstN)
    (accept && outcome == OUT_IGNORE) |=> (!rspErr && rspRdata == '0));

endmodule

// File: rtl/periph_access_filter.sv
`timescale 1ns/1ps
module periph_access_filter
  import paf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFFS_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        bootStrobe,
  input  logic [NUM_SLOTS-1:0]        bootEnMask,
  input  logic [NUM_SLOTS-1:0]        bootSecMask,
  input  logic                        bootTrap,
  input  logic                        bootCompact,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic                        reqSecure,
  output logic [NUM_SLOTS-1:0]        slotSel,
  output logic                        slotWrite,
  output logic [OFFS_W-1:0]           slotOffs,
  output logic [DATA_W-1:0]           slotWdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  output logic                        rspValid,
  output logic                        rspErr,
  output logic [DATA_W-1:0]           rspRdata
);

  ctlStrobes_t strobes;

  paf_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bootStrobe (bootStrobe),
    .strobes    (strobes)
  );

  paf_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .OFFS_W    (OFFS_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .bootEnMask  (bootEnMask),
    .bootSecMask (bootSecMask),
    .bootTrap    (bootTrap),
    .bootCompact (bootCompact),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .reqSecure   (reqSecure),
    .slotSel     (slotSel),
    .slotWrite   (slotWrite),
    .slotOffs    (slotOffs),
    .slotWdata   (slotWdata),
    .slotRdata   (slotRdata),
    .rspValid    (rspValid),
    .rspErr      (rspErr),
    .rspRdata    (rspRdata)
  );

  assign reqReady = strobes.runMode;

endmodule

// File: tb/sim_periph_access_filter.sv
`timescale 1ns/1ps
module sim_periph_access_filter;

  localparam int NS = 8;
  localparam int AW = 16;
  localparam int OW = 12;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            bootStrobe = 1'b0;
  logic [NS-1:0]   bootEnMask = '0;
  logic [NS-1:0]   bootSecMask = '0;
  logic            bootTrap = 1'b0;
  logic            bootCompact = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic            reqWrite = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic [DW-1:0]   reqWdata = '0;
  logic            reqSecure = 1'b0;
  logic [NS-1:0]   slotSel;
  logic            slotWrite;
  logic [OW-1:0]   slotOffs;
  logic [DW-1:0]   slotWdata;
  logic [NS*DW-1:0] slotRdata;
  logic            rspValid;
  logic            rspErr;
  logic [DW-1:0]   rspRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state (what the bench drove at boot)
  bit [NS-1:0] mEn;
  bit [NS-1:0] mSec;
  bit          mTrap;
  bit          mCompact;

  always #10 clk = ~clk;  // 50 MHz

  periph_access_filter u0 (
    .clk(clk), .rstN(rstN), .bootStrobe(bootStrobe),
    .bootEnMask(bootEnMask), .bootSecMask(bootSecMask),
    .bootTrap(bootTrap), .bootCompact(bootCompact),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSecure(reqSecure),
    .slotSel(slotSel), .slotWrite(slotWrite), .slotOffs(slotOffs),
    .slotWdata(slotWdata), .slotRdata(slotRdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata)
  );

  function automatic logic [DW-1:0] slotPattern(input int s, input logic [OW-1:0] o);
    return 32'hD000_0000 | (32'(s) << 16) | 32'(o);
  endfunction

  // Peripheral models: each slot answers with a tagged pattern
  always_comb begin
    for (int i = 0; i < NS; i++) slotRdata[i*DW +: DW] = slotPattern(i, slotOffs);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural prediction of one access
  task automatic predict(input logic [AW-1:0] addr, input bit sec, input bit wr,
                         output int slot, output bit err, output logic [DW-1:0] data);
    int q[$];
    int win;
    int tgt;
    win  = int'(addr >> OW);
    slot = -1;
    err  = 1'b0;
    data = '0;
    if (mCompact) begin
      for (int i = 0; i < NS; i++) if (mEn[i]) q.push_back(i);
      tgt = (win < q.size()) ? q[win] : -1;
    end else begin
      tgt = (win < NS) ? win : -1;
    end
    if (tgt < 0)                   err = 1'b1;
    else if (!mEn[tgt])            err = mTrap;
    else if (mSec[tgt] && !sec)    err = 1'b1;
    else begin
      slot = tgt;
      data = wr ? '0 : slotPattern(tgt, addr[OW-1:0]);
    end
  endtask

  // Starts and ends at a falling edge
  task automatic access(input bit wr, input logic [AW-1:0] addr, input bit sec,
                        input logic [DW-1:0] wd, input string req);
    int slot;
    bit err;
    logic [DW-1:0] data;
    logic [NS-1:0] expSel;
    predict(addr, sec, wr, slot, err, data);
    expSel   = (slot >= 0) ? NS'(1 << slot) : '0;
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqSecure = sec;
    reqWdata = wd;
    #2;
    chk(slotSel == expSel, req, "slotSel", 64'(slotSel), 64'(expSel));
    if (slot >= 0) begin
      chk(slotOffs == addr[OW-1:0], req, "slotOffs", 64'(slotOffs), 64'(addr[OW-1:0]));
      chk(slotWrite == wr, req, "slotWrite", 64'(slotWrite), 64'(wr));
      if (wr) chk(slotWdata == wd, req, "slotWdata", 64'(slotWdata), 64'(wd));
    end else begin
      chk(slotWrite == 1'b0, req, "slotWrite idle", 64'(slotWrite), 64'(0));
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
    chk(rspValid == 1'b1, "R9", "rspValid", 64'(rspValid), 64'(1));
    chk(rspErr == err, req, "rspErr", 64'(rspErr), 64'(err));
    chk(rspRdata == data, req, "rspRdata", 64'(rspRdata), 64'(data));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    bootStrobe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(reqReady == 1'b0, "R1", "reqReady after reset", 64'(reqReady), 64'(0));
    chk(rspValid == 1'b0, "R9", "rspValid after reset", 64'(rspValid), 64'(0));
    chk(slotSel == '0, "R1", "slotSel after reset", 64'(slotSel), 64'(0));
    repeat (3) begin
      @(negedge clk);
      chk(reqReady == 1'b0, "R1", "reqReady waiting for strobe", 64'(reqReady), 64'(0));
    end
  endtask

  task automatic boot(input bit [NS-1:0] en, input bit [NS-1:0] sec,
                      input bit trap, input bit compact);
    mEn = en; mSec = sec; mTrap = trap; mCompact = compact;
    bootEnMask = en; bootSecMask = sec; bootTrap = trap; bootCompact = compact;
    bootStrobe = 1'b1;
    @(posedge clk);
    for (int n = 0; n < NS; n++) begin
      @(negedge clk);
      bootStrobe = 1'b0;
      chk(reqReady == 1'b0, "R1", "reqReady during build", 64'(reqReady), 64'(0));
      @(posedge clk);
    end
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after build", 64'(reqReady), 64'(1));
    // scramble boot inputs: they must no longer matter (R2)
    bootEnMask = ~en; bootSecMask = ~sec; bootTrap = ~trap; bootCompact = ~compact;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Scenario A: direct map, holes trap, slot 3 secure
    doReset();
    boot(8'b1101_1011, 8'b0000_1000, 1'b1, 1'b0);
    access(1'b0, 16'h0010, 1'b0, '0, "R3");            // slot 0 read
    access(1'b1, 16'h4ABC, 1'b0, 32'h1234_5678, "R3");  // slot 4 write
    access(1'b0, 16'h7FFC, 1'b0, '0, "R3");            // slot 7 top offset
    access(1'b0, 16'h2000, 1'b0, '0, "R6");            // hole read
    access(1'b1, 16'h5004, 1'b0, 32'hDEAD_BEEF, "R6"); // hole write
    access(1'b0, 16'h3020, 1'b0, '0, "R8");            // secure slot, non-secure
    access(1'b0, 16'h3020, 1'b1, '0, "R8");            // secure slot, secure
    access(1'b1, 16'h9000, 1'b1, 32'h1, "R5");          // window 9
    @(negedge clk);
    chk(rspValid == 1'b0, "R9", "rspValid idle", 64'(rspValid), 64'(0));

    // R2: a second strobe with different settings changes nothing
    bootEnMask = 8'hFF; bootSecMask = 8'h00; bootTrap = 1'b0; bootCompact = 1'b1;
    bootStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bootStrobe = 1'b0;
    chk(reqReady == 1'b1, "R2", "reqReady after late strobe", 64'(reqReady), 64'(1));
    access(1'b0, 16'h2000, 1'b0, '0, "R2");   // still a trapped hole
    access(1'b0, 16'h3000, 1'b0, '0, "R2");   // still firewalled
    access(1'b0, 16'h1008, 1'b0, '0, "R2");   // still direct

    // Scenario B: direct map, holes absorbed
    doReset();
    boot(8'b1101_1011, 8'b0000_0000, 1'b0, 1'b0);
    access(1'b0, 16'h2040, 1'b0, '0, "R7");
    access(1'b1, 16'h5000, 1'b0, 32'hCAFE_0001, "R7");
    access(1'b0, 16'hF000, 1'b0, '0, "R5");   // beyond map even when absorbing
    access(1'b0, 16'h6100, 1'b0, '0, "R3");

    // Scenario C: packed map over slots 1,2,5,7; slot 7 secure
    doReset();
    boot(8'b1010_0110, 8'b1000_0000, 1'b0, 1'b1);
    access(1'b0, 16'h0004, 1'b0, '0, "R4");   // -> slot 1
    access(1'b0, 16'h1008, 1'b0, '0, "R4");   // -> slot 2
    access(1'b1, 16'h2ABC, 1'b0, 32'h0BAD_F00D, "R4"); // -> slot 5
    access(1'b0, 16'h3000, 1'b1, '0, "R4");   // -> slot 7 secure
    access(1'b0, 16'h3000, 1'b0, '0, "R8");   // slot 7 non-secure
    access(1'b0, 16'h4000, 1'b0, '0, "R5");   // past last packed window
    access(1'b1, 16'h7000, 1'b1, 32'h5, "R5");

    // Scenario D: packed with nothing fitted
    doReset();
    boot(8'b0000_0000, 8'b0000_0000, 1'b0, 1'b1);
    access(1'b0, 16'h0000, 1'b1, '0, "R5");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule